// File: doc/BRIEF.md
# Shared-ADC Conversion Sequencer

This controller schedules a single incremental delta-sigma converter that is time-shared between a shunt-current measurement and a die-temperature measurement. Once enabled it runs an endless sequence of slot pairs: a long current slot followed by a short temperature slot. During each slot it tells the analog front end which input is active and whether the shunt sampling switches may operate. It issues a one-cycle restart to the converter's integrators and decimator when a slot begins, and a one-cycle marker on the slot's last clock.

Inside every slot it derives three dynamic-error-correction controls from a single slot counter. These are a slow input chopper whose period is the slot length, a faster reference chopper, and a two-bit rotation pointer for the matched transistor pair. The faster rates are fixed multiples of the slow chopper, and the multiples differ between the two slot kinds. Every toggle point is rounded to a whole clock, and every control starts a slot in its zero state. In temperature slots the block also turns the modulator output bit into the two feedback path selects.

Clearing the enable lets the slot in progress finish, then parks every output low. The next enable starts a fresh current slot.

Top module: `adc_mux_sequencer`

## Requirements
- R1: While reset is asserted and after its release with `en` low, every output is 0.
- R2: When `en` is sampled high at a clock edge while idle, the next cycle is the first clock of a current slot: `conv_rst`=1 and `mode_tmp`=0.
- R3: Slots alternate without gaps, with current slots lasting CUR_CLKS (2250) clocks and temperature slots lasting TMP_CLKS (250) clocks. `conv_rst` is high exactly on a slot's first clock and `conv_done` exactly on its last.
- R4: With c the clock index inside a slot of length L (c=0 on the first clock), `chl` is 1 when c < L/2 (integer division) and 0 otherwise.
- R5: `bg_chop` equals bit 0 of floor(2·X·c/L). X is 18 in current slots and 2 in temperature slots.
- R6: `rot_ptr` equals floor(Y·c/L) mod 4. Y is 36 in current slots and 4 in temperature slots.
- R7: `shunt_samp_en` is 1 on every clock of a current slot and 0 in temperature slots and when idle. `mode_tmp` is 1 exactly on the clocks of temperature slots.
- R8: In a temperature slot, `bs`=1 gives `fb_vbe_neg`=1 and `fb_dvbe_pos`=0, and `bs`=0 gives the reverse, within the same cycle. In current slots and when idle, both selects are 0 for either value of `bs`.
- R9: If `en` is low on a slot's last clock, the sequence stops there. Every output is 0 from the next clock until `en` is seen high again, and the restart follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock (100 kHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run request; sampled at slot boundaries and while idle |
| bs | input | 1 | Modulator output bit |
| mode_tmp | output | 1 | 1 during temperature slots, 0 in current slots and idle; tag for the decimator |
| shunt_samp_en | output | 1 | Enables the shunt sampling switches (current slots only) |
| conv_rst | output | 1 | One-clock pulse on the first clock of each slot |
| conv_done | output | 1 | One-clock pulse on the last clock of each slot |
| chl | output | 1 | Slow input chopper, one period per slot |
| bg_chop | output | 1 | Reference chopper |
| rot_ptr | output | 2 | Matched-pair rotation pointer |
| fb_vbe_neg | output | 1 | Select for the negative base-emitter feedback path |
| fb_dvbe_pos | output | 1 | Select for the positive delta-VBE feedback path |

## Verification
A slot counter that is off by one moves `conv_rst` and `conv_done` away from their expected cycles. It also moves the `chl` edge by a clock. All of these show within one slot of the fault, and the full-period scan compares every cycle. A wrong step or threshold in either rate accumulator shifts the first `bg_chop` or `rot_ptr` transition, which shows on clock 63 of a slot, or leaves a nonzero value on the next `conv_rst` clock. A fault in mode or stop handling shows as a wrong `mode_tmp`, `shunt_samp_en` or feedback select on the clock after a slot boundary.

// File: rtl/adc_mux_seq_pkg.sv
package adc_mux_seq_pkg;

   // slot kind carried by the timer; 1 = temperature
   typedef enum logic {
      SLOT_CUR = 1'b0,
      SLOT_TMP = 1'b1
   } slot_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/seq_slot_timer.sv
module seq_slot_timer
   import adc_mux_seq_pkg::*;
#(
   parameter int unsigned CUR_CLKS = 2250,
   parameter int unsigned TMP_CLKS = 250,
   parameter int unsigned CW       = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic          active_o,
   output slot_e         kind_o,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] len_o,
   output logic          first_o,
   output logic          last_o
);

   localparam logic [CW-1:0] CUR_L = CW'(CUR_CLKS);
   localparam logic [CW-1:0] TMP_L = CW'(TMP_CLKS);

   logic          active_q;
   slot_e         kind_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_now;
   logic          at_end;

   assign len_now = (kind_q == SLOT_TMP) ? TMP_L : CUR_L;
   assign at_end  = active_q && (cnt_q == len_now - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         kind_q   <= SLOT_CUR;
         cnt_q    <= '0;
      end else if (!active_q) begin
         cnt_q  <= '0;
         kind_q <= SLOT_CUR;
         if (en) active_q <= 1'b1;
      end else if (at_end) begin
         cnt_q <= '0;
         if (en) begin
            kind_q <= (kind_q == SLOT_TMP) ? SLOT_CUR : SLOT_TMP;
         end else begin
            active_q <= 1'b0;
            kind_q   <= SLOT_CUR;
         end
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign active_o = active_q;
   assign kind_o   = kind_q;
   assign cnt_o    = cnt_q;
   assign len_o    = len_now;
   assign first_o  = active_q && (cnt_q == '0);
   assign last_o   = at_end;

   assert_cnt_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len_now);

   assert_start_current_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && en) |=> (active_q && kind_q == SLOT_CUR && cnt_q == '0));

   assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && en) |=> (active_q && cnt_q == '0 && kind_q != $past(kind_q)));

   assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !en) |=> !active_q);

   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (cnt_q == '0 && kind_q == SLOT_CUR));

endmodule

// File: rtl/seq_rate_gen.sv
module seq_rate_gen #(
   parameter int unsigned CW = 13,
   parameter int unsigned OW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [CW-1:0] step,
   input  logic [CW-1:0] len,
   output logic [OW-1:0] idx_o
);

   logic [CW-1:0] acc_q;
   logic [OW-1:0] idx_q;
   logic [CW:0]   sum;

   assign sum = {1'b0, acc_q} + {1'b0, step};

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc_q <= '0;
         idx_q <= '0;
      end else if (sum >= {1'b0, len}) begin
         acc_q <= CW'(sum - {1'b0, len});
         idx_q <= idx_q + OW'(1);
      end else begin
         acc_q <= sum[CW-1:0];
      end
   end

   assign idx_o = idx_q;

   assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < len);

   assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idx_q == '0));

endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
   import adc_mux_seq_pkg::*;
#(
   parameter int unsigned CUR_CLKS    = 2250,
   parameter int unsigned TMP_CLKS    = 250,
   parameter int unsigned CUR_CHOP_X  = 18,
   parameter int unsigned CUR_ROT_X   = 36,
   parameter int unsigned TMP_CHOP_X  = 2,
   parameter int unsigned TMP_ROT_X   = 4,
   parameter int unsigned ROT_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bs,
   output logic             mode_tmp,
   output logic             shunt_samp_en,
   output logic             conv_rst,
   output logic             conv_done,
   output logic             chl,
   output logic             bg_chop,
   output logic [ROT_W-1:0] rot_ptr,
   output logic             fb_vbe_neg,
   output logic             fb_dvbe_pos
);

   localparam int unsigned LMAX = max_u(CUR_CLKS, TMP_CLKS);
   localparam int unsigned CW   = $clog2(2 * LMAX + 1);
   localparam int unsigned ROTN = 1 << ROT_W;

   localparam logic [CW-1:0] CUR_CHOP_STEP = CW'(2 * CUR_CHOP_X);
   localparam logic [CW-1:0] TMP_CHOP_STEP = CW'(2 * TMP_CHOP_X);
   localparam logic [CW-1:0] CUR_ROT_STEP  = CW'(CUR_ROT_X);
   localparam logic [CW-1:0] TMP_ROT_STEP  = CW'(TMP_ROT_X);
   localparam logic [CW-1:0] CUR_HALF      = CW'(CUR_CLKS / 2);
   localparam logic [CW-1:0] TMP_HALF      = CW'(TMP_CLKS / 2);

   // elaboration-time parameter checks
   if (CUR_CLKS < 4 || TMP_CLKS < 4) begin : g_bad_len
      $error("slot lengths must be at least 4 clocks");
   end
   if (2 * CUR_CHOP_X >= CUR_CLKS || 2 * TMP_CHOP_X >= TMP_CLKS) begin : g_bad_chop
      $error("chopper rate too high for slot length");
   end
   if (CUR_ROT_X >= CUR_CLKS || TMP_ROT_X >= TMP_CLKS) begin : g_bad_rot
      $error("rotation rate too high for slot length");
   end
   if ((CUR_ROT_X % ROTN) != 0 || (TMP_ROT_X % ROTN) != 0) begin : g_bad_wrap
      $error("rotation count per slot must be a multiple of the pointer range");
   end
   if (ROT_W < 1) begin : g_bad_w
      $error("rotation pointer needs at least one bit");
   end

   logic          active;
   slot_e         kind;
   logic [CW-1:0] cnt;
   logic [CW-1:0] len;
   logic          first;
   logic          last;
   logic          is_tmp;
   logic          restart;
   logic [0:0]    chop_idx;
   logic [ROT_W-1:0] rot_idx;

   seq_slot_timer #(
      .CUR_CLKS (CUR_CLKS),
      .TMP_CLKS (TMP_CLKS),
      .CW       (CW)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .active_o (active),
      .kind_o   (kind),
      .cnt_o    (cnt),
      .len_o    (len),
      .first_o  (first),
      .last_o   (last)
   );

   assign is_tmp  = active && (kind == SLOT_TMP);
   assign restart = !active || last;

   seq_rate_gen #(
      .CW (CW),
      .OW (1)
   ) u_chop (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (is_tmp ? TMP_CHOP_STEP : CUR_CHOP_STEP),
      .len     (len),
      .idx_o   (chop_idx)
   );

   seq_rate_gen #(
      .CW (CW),
      .OW (ROT_W)
   ) u_rot (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (is_tmp ? TMP_ROT_STEP : CUR_ROT_STEP),
      .len     (len),
      .idx_o   (rot_idx)
   );

   assign mode_tmp      = is_tmp;
   assign shunt_samp_en = active && (kind == SLOT_CUR);
   assign conv_rst      = first;
   assign conv_done     = last;
   assign chl           = active && (cnt < (is_tmp ? TMP_HALF : CUR_HALF));
   assign bg_chop       = active && chop_idx[0];
   assign rot_ptr       = active ? rot_idx : '0;
   assign fb_vbe_neg    = is_tmp && bs;
   assign fb_dvbe_pos   = is_tmp && !bs;

   assert_samp_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(shunt_samp_en && mode_tmp));

   assert_fb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fb_vbe_neg, fb_dvbe_pos}));

   assert_fb_only_tmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_vbe_neg || fb_dvbe_pos) |-> mode_tmp);

   assert_rst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_rst |=> !conv_rst);

   assert_slot_start_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_rst |-> (!bg_chop && rot_ptr == '0 && chl));

   assert_done_then_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && en) |=> conv_rst);

   assert_parked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(shunt_samp_en || mode_tmp) |-> (!chl && !bg_chop && rot_ptr == '0 && !conv_rst));

endmodule

// File: tb/adc_mux_sequencer_tb.sv
module adc_mux_sequencer_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en;
   logic       bs;
   logic       mode_tmp, shunt_samp_en, conv_rst, conv_done, chl, bg_chop;
   logic [1:0] rot_ptr;
   logic       fb_vbe_neg, fb_dvbe_pos;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   adc_mux_sequencer u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .bs            (bs),
      .mode_tmp      (mode_tmp),
      .shunt_samp_en (shunt_samp_en),
      .conv_rst      (conv_rst),
      .conv_done     (conv_done),
      .chl           (chl),
      .bg_chop       (bg_chop),
      .rot_ptr       (rot_ptr),
      .fb_vbe_neg    (fb_vbe_neg),
      .fb_dvbe_pos   (fb_dvbe_pos)
   );

   // packed view: [7]mode [6]rst [5]done [4]chl [3]chop [2:1]ptr [0]samp
   function automatic logic [7:0] obs();
      return {mode_tmp, conv_rst, conv_done, chl, bg_chop, rot_ptr, shunt_samp_en};
   endfunction

   function automatic logic [7:0] spec_vec(input bit tmp, input int c);
      int L, x, y;
      logic [7:0] v;
      L = tmp ? 250 : 2250;
      x = tmp ? 2 : 18;
      y = tmp ? 4 : 36;
      v[7]   = tmp;
      v[6]   = (c == 0);
      v[5]   = (c == L - 1);
      v[4]   = (c < L / 2);
      v[3]   = ((2 * x * c) / L) % 2;
      v[2:1] = 2'((y * c) / L);
      v[0]   = !tmp;
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // hand-computed sample points, k counted from the first active clock
   localparam int NV = 12;
   localparam int VEC_K [NV] = '{0, 62, 63, 1124, 1125, 2249,
                                 2250, 2312, 2313, 2375, 2499, 2500};
   localparam logic [7:0] VEC_E [NV] = '{
      8'b0101_0001, 8'b0001_0001, 8'b0001_1011, 8'b0001_1011,
      8'b0000_0101, 8'b0010_1111, 8'b1101_0000, 8'b1001_0000,
      8'b1001_1010, 8'b1000_0100, 8'b1010_1110, 8'b0101_0001};

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int k;
      int errs;
      int c;
      bit tmp;
      rst_n = 1'b0;
      en    = 1'b0;
      bs    = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 outputs in reset", {obs(), fb_vbe_neg, fb_dvbe_pos}, '0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 idle after reset with en low", {obs(), fb_vbe_neg, fb_dvbe_pos}, '0);

      // start and walk the vector table
      en = 1'b1;
      @(negedge clk);
      k = 0;
      chk("R2 first clock is a current slot start", obs(), 8'b0101_0001);
      for (int i = 0; i < NV; i++) begin
         while (k < VEC_K[i]) begin
            @(negedge clk);
            k++;
         end
         chk($sformatf("R3 R4 R5 R6 R7 table k=%0d", VEC_K[i]), obs(), VEC_E[i]);
      end

      // full-period scan of one current and one temperature slot
      errs = 0;
      tmp  = 0;
      c    = 0;
      for (int i = 0; i < 2500; i++) begin
         if (obs() !== spec_vec(tmp, c)) begin
            if (errs == 0)
               $display("FAIL R3 R4 R5 R6 scan cyc %0d: actual %b expected %b",
                        i, obs(), spec_vec(tmp, c));
            errs++;
         end
         c++;
         if (c == (tmp ? 250 : 2250)) begin
            c   = 0;
            tmp = !tmp;
         end
         @(negedge clk);
      end
      n_checks++;
      if (errs != 0) n_fail++;

      // feedback selects: current slot start now
      bs = 1'b1; #1;
      chk("R8 current slot bs=1", {fb_vbe_neg, fb_dvbe_pos}, 2'b00);
      bs = 1'b0; #1;
      chk("R8 current slot bs=0", {fb_vbe_neg, fb_dvbe_pos}, 2'b00);
      repeat (2250) @(negedge clk);
      chk("R7 temperature slot tag", {mode_tmp, shunt_samp_en, conv_rst}, 3'b101);
      bs = 1'b1; #1;
      chk("R8 temperature bs=1", {fb_vbe_neg, fb_dvbe_pos}, 2'b10);
      bs = 1'b0; #1;
      chk("R8 temperature bs=0", {fb_vbe_neg, fb_dvbe_pos}, 2'b01);

      // stop during a temperature slot
      en = 1'b0;
      repeat (249) @(negedge clk);
      chk("R9 temperature slot completes", {mode_tmp, conv_done}, 2'b11);
      errs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         bs = i[0];
         #1;
         if ({obs(), fb_vbe_neg, fb_dvbe_pos} !== '0) errs++;
      end
      chk("R9 R8 parked outputs low", 32'(errs), 0);

      // restart, then stop during a current slot
      en = 1'b1;
      @(negedge clk);
      chk("R2 restart begins with current slot", obs(), 8'b0101_0001);
      repeat (10) @(negedge clk);
      en = 1'b0;
      repeat (2239) @(negedge clk);
      chk("R9 current slot completes", {conv_done, shunt_samp_en, mode_tmp}, 3'b110);
      @(negedge clk);
      chk("R9 no temperature slot after stop", {obs(), fb_vbe_neg, fb_dvbe_pos}, '0);
      repeat (5) @(negedge clk);
      chk("R9 still parked", obs(), 8'b0);

      // reset in the middle of a run
      en = 1'b1;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-slot clears outputs", obs(), 8'b0);
      en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule